// File: doc/BRIEF.md
# I2C Master Event Status and Interrupt Controller

This block keeps the status flags and interrupt masks of an I2C master. The transfer sequencer sends it single-cycle event pulses:
- a byte has been received;
- the bus wants the next byte to transmit;
- a transfer has started;
- the stop has completed;
- the addressed device answered with a NACK.

The host side sends it strobes for reading the receive holding register, writing the transmit holding register and reading the status register. From these it maintains six status flags, including overrun and underrun errors that it derives from the holding-register flags themselves.

Interrupt sources are enabled and disabled through two write-only strobed ports, one that sets mask bits and one that clears them. Writing 0 to a bit of either port leaves that mask bit untouched. The current mask is visible on a read-only output. A single registered interrupt line signals that any enabled status flag is set, and the host then reads the status word to find the cause.

Top module: `i2cm_event_status`

## Requirements
- R1: After reset the status word is 0x005 (transfer-complete and transmit-ready set, all else 0), the mask is 0 and the interrupt output is 0.
- R2: Status and mask share one bit layout: bit 0 transfer complete, bit 1 receive ready, bit 2 transmit ready, bit 6 overrun, bit 7 underrun, bit 8 NACK. Bits 3 to 5 always read 0 in both words.
- R3: A byte-received pulse sets receive ready in the next cycle. A receive-register read clears it. When both arrive together, the set wins.
- R4: A byte-received pulse while receive ready is already 1 sets overrun in the next cycle.
- R5: A transmit request while transmit ready is 0 sets transmit ready in the next cycle, because the byte has been taken. A transmit-register write clears transmit ready. When a set and a clear arrive together, the set wins.
- R6: A transmit request while transmit ready is 1 sets underrun in the next cycle. That request does not itself set transmit ready.
- R7: A transfer-start pulse clears transfer complete and a stop-done pulse sets it. When both arrive together, the start wins.
- R8: An address-NACK pulse sets both the NACK flag and transmit ready in the next cycle.
- R9: A status read clears overrun, underrun and NACK, but a set arriving in the same cycle wins. A status read leaves bits 0 to 2 unchanged.
- R10: Each 1 on the set-mask port sets the matching implemented mask bit, and each 1 on the clear-mask port clears it. Zeros on either port have no effect. When both ports hit the same bit in the same cycle, the clear wins.
- R11: The interrupt output equals the OR of (status AND mask) as it stood one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| ev_rx_byte | input | 1 | Sequencer pulse: a byte landed in the receive holding register |
| ev_tx_need | input | 1 | Sequencer pulse: the bus needs the next byte to send |
| ev_xfer_start | input | 1 | Sequencer pulse: a transfer has begun |
| ev_xfer_done | input | 1 | Sequencer pulse: the stop condition has completed |
| ev_addr_nack | input | 1 | Sequencer pulse: the device did not acknowledge |
| host_rhr_rd | input | 1 | Host read of the receive holding register |
| host_thr_wr | input | 1 | Host write of the transmit holding register |
| host_sr_rd | input | 1 | Host read of the status word |
| host_ien_wr | input | 1 | Host write to the set-mask port |
| host_idis_wr | input | 1 | Host write to the clear-mask port |
| host_wdata | input | 9 | Write data for the mask ports, status layout |
| status_o | output | 9 | Status word |
| mask_o | output | 9 | Interrupt mask, read-only view |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume that every event and host input is a synchronous level sampled once per clock, with no unknown values after reset. They do not assume that the inputs are mutually exclusive. Each property whose outcome depends on a competing input names that input in its antecedent, so that set-wins and clear-wins collisions never make it fire.

The stimulus raises each input independently with moderate probability. This deliberately produces collisions such as a read together with a set, start together with done, and set-mask together with clear-mask, so the stated priorities are exercised. A behavioural model judges every cycle.

// File: rtl/i2cm_stat_pkg.sv
package i2cm_stat_pkg;
  localparam int unsigned STAT_W   = 9;
  localparam int unsigned B_TXCOMP = 0;
  localparam int unsigned B_RXRDY  = 1;
  localparam int unsigned B_TXRDY  = 2;
  localparam int unsigned B_OVRE   = 6;
  localparam int unsigned B_UNRE   = 7;
  localparam int unsigned B_NACK   = 8;

  // Bits that exist in both status and mask words
  localparam logic [STAT_W-1:0] IMPL_BITS =
      (STAT_W'(1) << B_TXCOMP) | (STAT_W'(1) << B_RXRDY) |
      (STAT_W'(1) << B_TXRDY)  | (STAT_W'(1) << B_OVRE)  |
      (STAT_W'(1) << B_UNRE)   | (STAT_W'(1) << B_NACK);

  // Flags cleared by a status read
  localparam logic [STAT_W-1:0] ERR_BITS =
      (STAT_W'(1) << B_OVRE) | (STAT_W'(1) << B_UNRE) | (STAT_W'(1) << B_NACK);

  localparam logic [STAT_W-1:0] STAT_RST =
      (STAT_W'(1) << B_TXCOMP) | (STAT_W'(1) << B_TXRDY);
endpackage

// File: rtl/i2cm_rx_flags.sv
module i2cm_rx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_rx_byte,
  input  logic host_rhr_rd,
  input  logic host_sr_rd,
  output logic rxrdy_o,
  output logic ovre_o
);
  logic rxrdy_q, rxrdy_d, rxrdy_en;
  logic ovre_q, ovre_d, ovre_en;

  always_comb begin
    // set has priority over the host read
    rxrdy_en = ev_rx_byte | host_rhr_rd;
    rxrdy_d  = ev_rx_byte;
    // overrun: a new byte arrives while the previous is unread
    ovre_d   = ev_rx_byte & rxrdy_q;
    ovre_en  = ovre_d | host_sr_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxrdy_q <= 1'b0;
      ovre_q  <= 1'b0;
    end else begin
      if (rxrdy_en) rxrdy_q <= rxrdy_d;
      if (ovre_en)  ovre_q  <= ovre_d;
    end
  end

  assign rxrdy_o = rxrdy_q;
  assign ovre_o  = ovre_q;
endmodule

// File: rtl/i2cm_tx_flags.sv
module i2cm_tx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_tx_need,
  input  logic ev_xfer_start,
  input  logic ev_xfer_done,
  input  logic ev_addr_nack,
  input  logic host_thr_wr,
  input  logic host_sr_rd,
  output logic txcomp_o,
  output logic txrdy_o,
  output logic unre_o,
  output logic nack_o
);
  logic txrdy_q, txrdy_d, txrdy_en;
  logic unre_q, unre_d, unre_en;
  logic nack_q, nack_d, nack_en;
  logic txcomp_q, txcomp_d, txcomp_en;

  always_comb begin
    // holding register emptied by the bus, or forced free on a NACK
    txrdy_d   = (ev_tx_need & ~txrdy_q) | ev_addr_nack;
    txrdy_en  = txrdy_d | host_thr_wr;
    // bus asks for data that the host never supplied
    unre_d    = ev_tx_need & txrdy_q;
    unre_en   = unre_d | host_sr_rd;
    nack_d    = ev_addr_nack;
    nack_en   = nack_d | host_sr_rd;
    // start of a new transfer beats a stop completing in the same cycle
    txcomp_en = ev_xfer_start | ev_xfer_done;
    txcomp_d  = ~ev_xfer_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txrdy_q  <= 1'b1;
      unre_q   <= 1'b0;
      nack_q   <= 1'b0;
      txcomp_q <= 1'b1;
    end else begin
      if (txrdy_en)  txrdy_q  <= txrdy_d;
      if (unre_en)   unre_q   <= unre_d;
      if (nack_en)   nack_q   <= nack_d;
      if (txcomp_en) txcomp_q <= txcomp_d;
    end
  end

  assign txrdy_o  = txrdy_q;
  assign unre_o   = unre_q;
  assign nack_o   = nack_q;
  assign txcomp_o = txcomp_q;
endmodule

// File: rtl/i2cm_irq_ctrl.sv
module i2cm_irq_ctrl
  import i2cm_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_ien_wr,
  input  logic              host_idis_wr,
  input  logic [STAT_W-1:0] host_wdata,
  input  logic [STAT_W-1:0] status_i,
  output logic [STAT_W-1:0] mask_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] mask_q, mask_d, set_v, clr_v;
  logic              mask_en;
  logic              irq_q, irq_d;

  always_comb begin
    set_v   = host_ien_wr  ? (host_wdata & IMPL_BITS) : '0;
    clr_v   = host_idis_wr ? host_wdata : '0;
    mask_en = host_ien_wr | host_idis_wr;
    // clear applied last, so it wins on a shared bit
    mask_d  = (mask_q | set_v) & ~clr_v;
    irq_d   = |(status_i & mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_en) mask_q <= mask_d;
      irq_q <= irq_d;
    end
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/i2cm_event_status.sv
module i2cm_event_status
  import i2cm_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_rx_byte,
  input  logic              ev_tx_need,
  input  logic              ev_xfer_start,
  input  logic              ev_xfer_done,
  input  logic              ev_addr_nack,
  input  logic              host_rhr_rd,
  input  logic              host_thr_wr,
  input  logic              host_sr_rd,
  input  logic              host_ien_wr,
  input  logic              host_idis_wr,
  input  logic [STAT_W-1:0] host_wdata,
  output logic [STAT_W-1:0] status_o,
  output logic [STAT_W-1:0] mask_o,
  output logic              irq_o
);
  logic rxrdy, ovre, txcomp, txrdy, unre, nack;
  logic [STAT_W-1:0] status_w;

  i2cm_rx_flags u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_rx_byte  (ev_rx_byte),
    .host_rhr_rd (host_rhr_rd),
    .host_sr_rd  (host_sr_rd),
    .rxrdy_o     (rxrdy),
    .ovre_o      (ovre)
  );

  i2cm_tx_flags u_tx (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_tx_need    (ev_tx_need),
    .ev_xfer_start (ev_xfer_start),
    .ev_xfer_done  (ev_xfer_done),
    .ev_addr_nack  (ev_addr_nack),
    .host_thr_wr   (host_thr_wr),
    .host_sr_rd    (host_sr_rd),
    .txcomp_o      (txcomp),
    .txrdy_o       (txrdy),
    .unre_o        (unre),
    .nack_o        (nack)
  );

  always_comb begin
    status_w           = '0;
    status_w[B_TXCOMP] = txcomp;
    status_w[B_RXRDY]  = rxrdy;
    status_w[B_TXRDY]  = txrdy;
    status_w[B_OVRE]   = ovre;
    status_w[B_UNRE]   = unre;
    status_w[B_NACK]   = nack;
  end

  i2cm_irq_ctrl u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_ien_wr  (host_ien_wr),
    .host_idis_wr (host_idis_wr),
    .host_wdata   (host_wdata),
    .status_i     (status_w),
    .mask_o       (mask_o),
    .irq_o        (irq_o)
  );

  assign status_o = status_w;
endmodule

// File: rtl/i2cm_event_status_chk.sv
module i2cm_event_status_chk
  import i2cm_stat_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ev_rx_byte,
  input logic              ev_tx_need,
  input logic              ev_xfer_start,
  input logic              ev_xfer_done,
  input logic              ev_addr_nack,
  input logic              host_rhr_rd,
  input logic              host_thr_wr,
  input logic              host_sr_rd,
  input logic              host_ien_wr,
  input logic              host_idis_wr,
  input logic [STAT_W-1:0] host_wdata,
  input logic [STAT_W-1:0] status_o,
  input logic [STAT_W-1:0] mask_o,
  input logic              irq_o
);
  AST_RXRDY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_byte |=> status_o[B_RXRDY]); // R3
  AST_RXRDY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    host_rhr_rd && !ev_rx_byte |=> !status_o[B_RXRDY]); // R3
  AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_byte && status_o[B_RXRDY] |=> status_o[B_OVRE]); // R4
  AST_TXRDY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    host_thr_wr && !ev_tx_need && !ev_addr_nack |=> !status_o[B_TXRDY]); // R5
  AST_TXRDY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_need && !status_o[B_TXRDY] |=> status_o[B_TXRDY]); // R5
  AST_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_need && status_o[B_TXRDY] |=> status_o[B_UNRE]); // R6
  AST_TXCOMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ev_xfer_start |=> !status_o[B_TXCOMP]); // R7
  AST_TXCOMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_xfer_done && !ev_xfer_start |=> status_o[B_TXCOMP]); // R7
  AST_NACK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_nack |=> status_o[B_NACK] && status_o[B_TXRDY]); // R8
  AST_ERR_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    host_sr_rd && !ev_rx_byte && !ev_tx_need && !ev_addr_nack
      |=> (status_o & ERR_BITS) == '0); // R9
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    host_ien_wr && !host_idis_wr
      |=> (mask_o & $past(host_wdata & IMPL_BITS)) == $past(host_wdata & IMPL_BITS)); // R10
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    host_idis_wr |=> (mask_o & $past(host_wdata)) == '0); // R10
  AST_IRQ_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_o == |($past(status_o & mask_o))); // R11
endmodule

bind i2cm_event_status i2cm_event_status_chk u_chk (.*);

// File: tb/test_i2cm_event_status.sv
`timescale 1ns/1ps
module test_i2cm_event_status;
  logic       clk;
  logic       rst_n;
  logic       ev_rx_byte, ev_tx_need, ev_xfer_start, ev_xfer_done, ev_addr_nack;
  logic       host_rhr_rd, host_thr_wr, host_sr_rd, host_ien_wr, host_idis_wr;
  logic [8:0] host_wdata;
  logic [8:0] status_o, mask_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 0;
  bit done_flag = 0;

  // stimulus vector bits
  localparam int K_RX = 1, K_TXN = 2, K_ST = 4, K_DN = 8, K_NK = 16;
  localparam int K_RRD = 32, K_TWR = 64, K_SRD = 128, K_IEN = 256, K_IDIS = 512;

  i2cm_event_status i_i2cm_event_status (
    .clk(clk), .rst_n(rst_n),
    .ev_rx_byte(ev_rx_byte), .ev_tx_need(ev_tx_need),
    .ev_xfer_start(ev_xfer_start), .ev_xfer_done(ev_xfer_done),
    .ev_addr_nack(ev_addr_nack),
    .host_rhr_rd(host_rhr_rd), .host_thr_wr(host_thr_wr), .host_sr_rd(host_sr_rd),
    .host_ien_wr(host_ien_wr), .host_idis_wr(host_idis_wr), .host_wdata(host_wdata),
    .status_o(status_o), .mask_o(mask_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural reference model, evaluated at every rising edge
  logic [8:0] m_st, m_mask, s_n, mk_n;
  logic       m_irq;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 9'h005; m_mask = 9'h000; m_irq = 1'b0;
    end else begin
      m_irq = (m_st & m_mask) != 9'h000;
      s_n = m_st;
      if (host_rhr_rd) s_n[1] = 1'b0;
      if (host_thr_wr) s_n[2] = 1'b0;
      if (host_sr_rd)  s_n[8:6] = 3'b000;
      if (ev_rx_byte) begin
        if (m_st[1]) s_n[6] = 1'b1;
        s_n[1] = 1'b1;
      end
      if (ev_tx_need) begin
        if (m_st[2]) s_n[7] = 1'b1;
        else         s_n[2] = 1'b1;
      end
      if (ev_addr_nack) begin s_n[8] = 1'b1; s_n[2] = 1'b1; end
      if (ev_xfer_done)  s_n[0] = 1'b1;
      if (ev_xfer_start) s_n[0] = 1'b0;
      mk_n = m_mask;
      if (host_ien_wr)  mk_n = mk_n | (host_wdata & 9'h1C7);
      if (host_idis_wr) mk_n = mk_n & ~host_wdata;
      m_st = s_n;
      m_mask = mk_n;
    end
  end

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk("R7 transfer complete bit", {8'b0, status_o[0]}, {8'b0, m_st[0]});
      chk("R3 receive ready bit",     {8'b0, status_o[1]}, {8'b0, m_st[1]});
      chk("R5 R8 transmit ready bit", {8'b0, status_o[2]}, {8'b0, m_st[2]});
      chk("R2 unused status bits",    {6'b0, status_o[5:3]}, 9'h000);
      chk("R4 R9 overrun bit",        {8'b0, status_o[6]}, {8'b0, m_st[6]});
      chk("R6 R9 underrun bit",       {8'b0, status_o[7]}, {8'b0, m_st[7]});
      chk("R8 R9 nack bit",           {8'b0, status_o[8]}, {8'b0, m_st[8]});
      chk("R10 mask word",            mask_o, m_mask);
      chk("R11 interrupt",            {8'b0, irq_o}, {8'b0, m_irq});
    end
  end

  task automatic cyc(input int v, input logic [8:0] wd);
    ev_rx_byte    = v[0];
    ev_tx_need    = v[1];
    ev_xfer_start = v[2];
    ev_xfer_done  = v[3];
    ev_addr_nack  = v[4];
    host_rhr_rd   = v[5];
    host_thr_wr   = v[6];
    host_sr_rd    = v[7];
    host_ien_wr   = v[8];
    host_idis_wr  = v[9];
    host_wdata    = wd;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    rst_n = 1'b0;
    ev_rx_byte = 0; ev_tx_need = 0; ev_xfer_start = 0; ev_xfer_done = 0;
    ev_addr_nack = 0; host_rhr_rd = 0; host_thr_wr = 0; host_sr_rd = 0;
    host_ien_wr = 0; host_idis_wr = 0; host_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    chk("R1 status after reset", status_o, 9'h005);
    chk("R1 mask after reset",   mask_o,   9'h000);
    chk("R1 irq after reset",    {8'b0, irq_o}, 9'h000);
    cmp_on = 1;

    // R4 then R9: two bytes without a read, then a status read
    cyc(K_RX, '0); cyc(K_RX, '0); cyc(0, '0);
    chk("R4 overrun after second byte", {8'b0, status_o[6]}, 9'h001);
    cyc(K_SRD, '0);
    chk("R9 overrun cleared by status read", {8'b0, status_o[6]}, 9'h000);
    chk("R9 receive ready kept by status read", {8'b0, status_o[1]}, 9'h001);

    // R10 set all, then clear-wins collision on bit 1
    cyc(K_IEN, 9'h1FF);
    chk("R10 set all implemented bits", mask_o, 9'h1C7);
    cyc(K_IEN | K_IDIS, 9'h002);
    chk("R10 clear wins over set", mask_o, 9'h1C5);
    cyc(0, '0);
    chk("R11 irq from enabled flags", {8'b0, irq_o}, 9'h001);

    // R8 address nack
    cyc(K_TWR, '0);
    cyc(K_NK, '0);
    chk("R8 nack and transmit ready", {7'b0, status_o[8], status_o[2]}, 9'h003);

    // R7 start beats done
    cyc(K_ST | K_DN, '0);
    chk("R7 start wins over done", {8'b0, status_o[0]}, 9'h000);

    // R5 and R6 transmit path
    cyc(K_TWR, '0);
    cyc(K_TXN, '0);
    chk("R5 transmit ready after byte taken", {8'b0, status_o[2]}, 9'h001);
    cyc(K_TXN, '0);
    chk("R6 underrun when register empty", {8'b0, status_o[7]}, 9'h001);

    // random collisions, judged by the model every cycle
    for (int n = 0; n < 4000; n++) begin
      int v;
      v = 0;
      for (int k = 0; k < 10; k++)
        if ($urandom_range(4) == 0) v = v | (1 << k);
      cyc(v, 9'($urandom));
    end
    cyc(0, '0);
    cmp_on = 0;
    done_flag = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule